// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Controller

This block holds the data-hazard decisions for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). Each cycle it compares the source register numbers of the instruction in execute with the destinations of the two older instructions further down the pipe. From that it picks, for each ALU operand, whether the value comes from the register file, from the result held after execute, or from the value being written back. This lets a dependent instruction use an ALU result as soon as it exists.

A load cannot hand its data over in time to the instruction right behind it. The block therefore also compares the destination of a load in execute with both source registers of the instruction in decode. On a match it freezes the program counter and the fetch/decode register for one cycle and turns the decode/execute slot into a no-op. The older instructions keep moving. In the next cycle the loaded value reaches write-back and the bypass path delivers it.

A register written in write-back is not bypassed into decode. The register file is assumed to write in the first half of a cycle and read in the second, so a decode-stage read already sees that value. The whole block is combinational. While reset is held it drives quiet outputs.

Top module: `hzu_forward_stall`

## Requirements
- R1: When the post-execute stage writes a nonzero register equal to an execute source, that operand's select is 2'b10. The select for operand A follows `ex_src_a` and the select for operand B follows `ex_src_b`.
- R2: When the write-back stage writes a nonzero register equal to an execute source, and R1 does not apply to that operand, that operand's select is 2'b01.
- R3: When both stages match the same operand, the post-execute source wins and the select is 2'b10.
- R4: Register 0 as a destination never produces a nonzero select and never raises a stall.
- R5: A stage whose write enable is low is never chosen as a bypass source, even if its register number matches.
- R6: An operand that matches no eligible stage selects the register file, 2'b00. The value 2'b11 never appears.
- R7: When the execute instruction is a load with a nonzero destination equal to either decode source, `hold_front` and `insert_bubble` are both 1.
- R8: `hold_front` and `insert_bubble` are always equal, and both are 0 whenever the execute instruction is not a load.
- R9: A write-back destination matching a decode source never raises a stall.
- R10: While `rst_n` is low, both selects are 2'b00 and both stall outputs are 0, whatever the other inputs are.
- R11: The two operand selects are decided independently, so operand A and operand B can pick different sources in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used to sample the bound checks |
| rst_n | input | 1 | Active-low reset; quiets all outputs while low |
| ex_src_a | input | REG_ADDR_W | First source register of the execute instruction |
| ex_src_b | input | REG_ADDR_W | Second source register of the execute instruction |
| id_src_a | input | REG_ADDR_W | First source register of the decode instruction |
| id_src_b | input | REG_ADDR_W | Second source register of the decode instruction |
| ex_dst | input | REG_ADDR_W | Destination register of the execute instruction |
| ex_is_load | input | 1 | Execute instruction is a memory load |
| mem_dst | input | REG_ADDR_W | Destination in the post-execute (memory) stage |
| mem_wr | input | 1 | Post-execute stage will write its destination |
| wb_dst | input | REG_ADDR_W | Destination in the write-back stage |
| wb_wr | input | 1 | Write-back stage writes its destination |
| sel_a | output | 2 | Operand A source: 00 register file, 10 post-execute, 01 write-back |
| sel_b | output | 2 | Operand B source, same encoding as `sel_a` |
| hold_front | output | 1 | Freeze the program counter and the fetch/decode register |
| insert_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The block has no state, so a bad decision shows up at the ports in the same cycle as the input pattern that causes it. A wrong priority or a missing zero guard gives a select that points at a stale or illegal source. A wrong compare in the load check either leaves a load-use pair unstalled or stalls a pair that bypass alone could serve. Each input pattern is therefore checked against its expected selects and stall in the cycle it is applied. The patterns cover the priority overlap, register 0, a disabled write, both decode sources and the cycle after a stall.

// File: rtl/hzu_pkg.sv
// Shared types for the operand bypass and load-use stall controller.
// Assumes a two-bit select feeding a three-input operand multiplexer.
package hzu_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_WB      = 2'b01,
        SRC_MEM     = 2'b10
    } src_sel_e;
endpackage

// File: rtl/hzu_dst_match.sv
// Compares one consumer register number against one producer destination.
// Assumes register 0 is hard-wired to zero, so it never counts as a match.
module hzu_dst_match #(
    parameter int REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] src,
    input  logic [REG_ADDR_W-1:0] dst,
    input  logic                  dst_valid,
    output logic                  hit
);
    localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

    // Match only a real, nonzero write to the same register.
    always_comb begin
        hit = dst_valid && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/hzu_operand_sel.sv
// Picks the bypass source for one execute-stage operand.
// Assumes the post-execute result is newer than the write-back value and so wins.
module hzu_operand_sel
    import hzu_pkg::*;
#(
    parameter int REG_ADDR_W = 5
) (
    input  logic [REG_ADDR_W-1:0] src,
    input  logic [REG_ADDR_W-1:0] mem_dst,
    input  logic                  mem_wr,
    input  logic [REG_ADDR_W-1:0] wb_dst,
    input  logic                  wb_wr,
    output src_sel_e              sel
);
    logic mem_hit;
    logic wb_hit;

    hzu_dst_match #(.REG_ADDR_W(REG_ADDR_W)) u_mem_cmp (
        .src(src), .dst(mem_dst), .dst_valid(mem_wr), .hit(mem_hit)
    );

    hzu_dst_match #(.REG_ADDR_W(REG_ADDR_W)) u_wb_cmp (
        .src(src), .dst(wb_dst), .dst_valid(wb_wr), .hit(wb_hit)
    );

    // Priority choice: newest producer first, register file last.
    always_comb begin
        if (mem_hit)     sel = SRC_MEM;
        else if (wb_hit) sel = SRC_WB;
        else             sel = SRC_REGFILE;
    end
endmodule

// File: rtl/hzu_load_use.sv
// Flags a decode instruction that reads the destination of a load in execute.
// Assumes the loaded data is ready no earlier than the end of the memory stage.
module hzu_load_use #(
    parameter int REG_ADDR_W = 5,
    parameter int NUM_ID_SRC = 2
) (
    input  logic [NUM_ID_SRC-1:0][REG_ADDR_W-1:0] id_src,
    input  logic [REG_ADDR_W-1:0]                 ex_dst,
    input  logic                                  ex_is_load,
    output logic                                  stall
);
    logic [NUM_ID_SRC-1:0] src_hit;

    // One comparator per decode source, enabled only by a load.
    for (genvar i = 0; i < NUM_ID_SRC; i++) begin : g_src
        hzu_dst_match #(.REG_ADDR_W(REG_ADDR_W)) u_cmp (
            .src(id_src[i]), .dst(ex_dst), .dst_valid(ex_is_load), .hit(src_hit[i])
        );
    end

    // Any dependent source forces the single stall cycle.
    always_comb begin
        stall = |src_hit;
    end
endmodule

// File: rtl/hzu_forward_stall.sv
// Top of the data-hazard controller: two operand bypass selects plus the load-use stall.
// Assumes a register file that writes early and reads late in the cycle, so no
// write-back to decode bypass exists. Purely combinational; reset only quiets outputs.
module hzu_forward_stall
    import hzu_pkg::*;
#(
    parameter int REG_ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] ex_src_a,
    input  logic [REG_ADDR_W-1:0] ex_src_b,
    input  logic [REG_ADDR_W-1:0] id_src_a,
    input  logic [REG_ADDR_W-1:0] id_src_b,
    input  logic [REG_ADDR_W-1:0] ex_dst,
    input  logic                  ex_is_load,
    input  logic [REG_ADDR_W-1:0] mem_dst,
    input  logic                  mem_wr,
    input  logic [REG_ADDR_W-1:0] wb_dst,
    input  logic                  wb_wr,
    output logic [1:0]            sel_a,
    output logic [1:0]            sel_b,
    output logic                  hold_front,
    output logic                  insert_bubble
);
    localparam int NUM_OPERANDS = 2;
    localparam int NUM_ID_SRC   = 2;

    logic [NUM_OPERANDS-1:0][REG_ADDR_W-1:0] ex_src;
    logic [NUM_ID_SRC-1:0][REG_ADDR_W-1:0]   id_src;
    src_sel_e                                op_sel [NUM_OPERANDS];
    logic                                    lu_stall;

    // Gather the operand numbers into arrays for the generated lanes.
    always_comb begin
        ex_src[0] = ex_src_a;
        ex_src[1] = ex_src_b;
        id_src[0] = id_src_a;
        id_src[1] = id_src_b;
    end

    // One bypass selector per ALU operand.
    for (genvar k = 0; k < NUM_OPERANDS; k++) begin : g_op
        hzu_operand_sel #(.REG_ADDR_W(REG_ADDR_W)) u_sel (
            .src(ex_src[k]), .mem_dst(mem_dst), .mem_wr(mem_wr),
            .wb_dst(wb_dst), .wb_wr(wb_wr), .sel(op_sel[k])
        );
    end

    hzu_load_use #(.REG_ADDR_W(REG_ADDR_W), .NUM_ID_SRC(NUM_ID_SRC)) u_lu (
        .id_src(id_src), .ex_dst(ex_dst), .ex_is_load(ex_is_load), .stall(lu_stall)
    );

    // Drive outputs, held quiet while reset is asserted.
    always_comb begin
        if (!rst_n) begin
            sel_a         = SRC_REGFILE;
            sel_b         = SRC_REGFILE;
            hold_front    = 1'b0;
            insert_bubble = 1'b0;
        end else begin
            sel_a         = op_sel[0];
            sel_b         = op_sel[1];
            hold_front    = lu_stall;
            insert_bubble = lu_stall;
        end
    end
endmodule

// File: rtl/hzu_forward_stall_chk.sv
// Checker for the data-hazard controller, bound to the top module.
// Assumes inputs are stable at the rising clock edge where it samples.
module hzu_forward_stall_chk #(
    parameter int REG_ADDR_W = 5
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [REG_ADDR_W-1:0] ex_src_a,
    input logic [REG_ADDR_W-1:0] ex_src_b,
    input logic [REG_ADDR_W-1:0] id_src_a,
    input logic [REG_ADDR_W-1:0] id_src_b,
    input logic [REG_ADDR_W-1:0] ex_dst,
    input logic                  ex_is_load,
    input logic [REG_ADDR_W-1:0] mem_dst,
    input logic                  mem_wr,
    input logic [REG_ADDR_W-1:0] wb_dst,
    input logic                  wb_wr,
    input logic [1:0]            sel_a,
    input logic [1:0]            sel_b,
    input logic                  hold_front,
    input logic                  insert_bubble
);
    p_mem_wins_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_dst != 0 && mem_dst == ex_src_a) |-> sel_a == 2'b10);

    p_mem_wins_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_dst != 0 && mem_dst == ex_src_b) |-> sel_b == 2'b10);

    p_wb_src_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_wr && wb_dst != 0 && wb_dst == ex_src_a &&
         !(mem_wr && mem_dst == ex_src_a)) |-> sel_a == 2'b01);

    p_zero_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src_a == 0) |-> sel_a == 2'b00);

    p_zero_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == 0) |-> !hold_front);

    p_legal_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a != 2'b11 && sel_b != 2'b11);

    p_load_use_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_dst != 0 && (ex_dst == id_src_a || ex_dst == id_src_b))
        |-> hold_front && insert_bubble);

    p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_front == insert_bubble);

    p_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !hold_front);

    // R10: quiet outputs while reset is held.
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r10: assert (sel_a == 2'b00 && sel_b == 2'b00 &&
                                       !hold_front && !insert_bubble);
        end
    end
endmodule

bind hzu_forward_stall hzu_forward_stall_chk #(.REG_ADDR_W(REG_ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .ex_dst(ex_dst), .ex_is_load(ex_is_load),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst), .wb_wr(wb_wr),
    .sel_a(sel_a), .sel_b(sel_b), .hold_front(hold_front), .insert_bubble(insert_bubble)
);

// File: tb/hzu_forward_stall_test.sv
`timescale 1ns/1ps
module hzu_forward_stall_test;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ex_src_a = '0, ex_src_b = '0, id_src_a = '0, id_src_b = '0;
    logic [W-1:0] ex_dst = '0, mem_dst = '0, wb_dst = '0;
    logic         ex_is_load = 1'b0, mem_wr = 1'b0, wb_wr = 1'b0;
    logic [1:0]   sel_a, sel_b;
    logic         hold_front, insert_bubble;

    typedef struct {
        logic [1:0] a;
        logic [1:0] b;
        logic       st;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    hzu_forward_stall #(.REG_ADDR_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .id_src_a(id_src_a), .id_src_b(id_src_b), .ex_dst(ex_dst), .ex_is_load(ex_is_load),
        .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst), .wb_wr(wb_wr),
        .sel_a(sel_a), .sel_b(sel_b), .hold_front(hold_front), .insert_bubble(insert_bubble)
    );

    // Driver: apply one pattern on the falling edge and queue its expected result.
    task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                         input logic [W-1:0] ia, input logic [W-1:0] ib,
                         input logic [W-1:0] md, input logic mw,
                         input logic [W-1:0] wd, input logic ww,
                         input logic [W-1:0] ed, input logic ld,
                         input logic [1:0] ea, input logic [1:0] eb,
                         input logic est, input string tag);
        exp_t e;
        @(negedge clk);
        ex_src_a = xa; ex_src_b = xb; id_src_a = ia; id_src_b = ib;
        mem_dst = md; mem_wr = mw; wb_dst = wd; wb_wr = ww;
        ex_dst = ed; ex_is_load = ld;
        e.a = ea; e.b = eb; e.st = est; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: after each rising edge compare the ports with the queued item.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (sel_a !== e.a || sel_b !== e.b ||
                    hold_front !== e.st || insert_bubble !== e.st) begin
                    bad++;
                    $display("FAIL %s: sel_a=%b sel_b=%b hold=%b bubble=%b expected %b %b %b %b",
                             e.tag, sel_a, sel_b, hold_front, insert_bubble,
                             e.a, e.b, e.st, e.st);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: every hazard present, reset held -> quiet outputs
        drive(5'd3, 5'd4, 5'd4, 5'd0, 5'd3, 1'b1, 5'd4, 1'b1, 5'd4, 1'b1, 2'b00, 2'b00, 1'b0, "R10");
        @(negedge clk); rst_n = 1'b1;
        // R6: nothing matches
        drive(5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 1'b1, 5'd6, 1'b1, 5'd7, 1'b0, 2'b00, 2'b00, 1'b0, "R6");
        // R1: post-execute bypass on operand A, then operand B
        drive(5'd3, 5'd7, 5'd0, 5'd0, 5'd3, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0, "R1");
        drive(5'd7, 5'd3, 5'd0, 5'd0, 5'd3, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b10, 1'b0, "R1");
        // R1: top register number
        drive(5'd31, 5'd30, 5'd0, 5'd0, 5'd31, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b10, 2'b00, 1'b0, "R1");
        // R2: write-back bypass
        drive(5'd5, 5'd9, 5'd0, 5'd0, 5'd2, 1'b1, 5'd5, 1'b1, 5'd0, 1'b0, 2'b01, 2'b00, 1'b0, "R2");
        // R3: both stages match both operands
        drive(5'd6, 5'd6, 5'd0, 5'd0, 5'd6, 1'b1, 5'd6, 1'b1, 5'd0, 1'b0, 2'b10, 2'b10, 1'b0, "R3");
        // R11: operands pick different stages
        drive(5'd9, 5'd8, 5'd0, 5'd0, 5'd8, 1'b1, 5'd9, 1'b1, 5'd0, 1'b0, 2'b01, 2'b10, 1'b0, "R11");
        // R4: register 0 never forwarded
        drive(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, "R4");
        // R4: load to register 0 never stalls
        drive(5'd1, 5'd2, 5'd0, 5'd0, 5'd4, 1'b0, 5'd5, 1'b0, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0, "R4");
        // R5: disabled writes ignored
        drive(5'd3, 5'd3, 5'd0, 5'd0, 5'd3, 1'b0, 5'd3, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, "R5");
        // R5: disabled post-execute falls through to write-back
        drive(5'd3, 5'd1, 5'd0, 5'd0, 5'd3, 1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 2'b01, 2'b00, 1'b0, "R5");
        // R7: load-use on decode source A, then source B
        drive(5'd1, 5'd2, 5'd12, 5'd4, 5'd0, 1'b0, 5'd0, 1'b0, 5'd12, 1'b1, 2'b00, 2'b00, 1'b1, "R7");
        drive(5'd1, 5'd2, 5'd4, 5'd12, 5'd0, 1'b0, 5'd0, 1'b0, 5'd12, 1'b1, 2'b00, 2'b00, 1'b1, "R7");
        // R7: load with no dependent reader
        drive(5'd1, 5'd2, 5'd11, 5'd13, 5'd0, 1'b0, 5'd0, 1'b0, 5'd12, 1'b1, 2'b00, 2'b00, 1'b0, "R7");
        // R8: ALU producer in execute does not stall
        drive(5'd1, 5'd2, 5'd12, 5'd12, 5'd0, 1'b0, 5'd0, 1'b0, 5'd12, 1'b0, 2'b00, 2'b00, 1'b0, "R8");
        // R9: write-back destination read in decode does not stall
        drive(5'd1, 5'd2, 5'd14, 5'd14, 5'd0, 1'b0, 5'd14, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, "R9");
        // R2: after the stall the load sits in write-back and is bypassed
        drive(5'd12, 5'd4, 5'd0, 5'd0, 5'd0, 1'b0, 5'd12, 1'b1, 5'd0, 1'b0, 2'b01, 2'b00, 1'b0, "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule